// File: doc/BRIEF.md
# Flash Program and Erase Execution Engine

This block is the execution side of a byte-wide flash memory model. A separate command decoder, which recognises the unlock sequences, hands it single-cycle strobes: program one byte, erase the whole array, or enable write protection of the low boot region. The engine holds the array, runs each accepted operation over a busy interval of a fixed number of clock cycles, and commits the result when that interval ends.

While an operation runs, reads do not return array contents. They return a polling status byte instead. Bit 7 is the inverse of bit 7 of the byte being written. Bit 6 flips on every read. Software therefore watches either bit to detect completion. Bits may only be cleared by programming and only be set by erasing. Once protection is on, the boot region can no longer be programmed or erased until reset.

Top module: `flash_eng`

## Requirements
- R1: After reset `busy` is low, protection is off, and every array byte reads 0xFF.
- R2: With `busy` low, a read strobe returns the stored byte at `rd_addr` on `rd_data` one cycle later.
- R3: An accepted program request raises `busy` from the next cycle for exactly PROG_CYC cycles. At the end, the stored byte becomes the old byte AND `op_data`.
- R4: An accepted erase request raises `busy` from the next cycle for exactly ERASE_CYC cycles. At the end, every unprotected byte becomes 0xFF.
- R5: A read issued while `busy` is high returns a status byte. Its bits 5:0 are zero. Its bit 7 is the inverse of bit 7 of the programmed data during a program, and 0 during an erase.
- R6: Bit 6 of successive status reads alternates. The first status read of each operation returns 0.
- R7: Program, erase and protect requests that arrive while `busy` is high have no effect.
- R8: A protect request sets a protection flag that only reset clears. While the flag is set, a program request to an address below 2**BOOT_W is dropped: `busy` stays low and the byte is unchanged.
- R9: An erase performed while protection is set leaves every byte below 2**BOOT_W unchanged.
- R10: When requests coincide with `busy` low, only one is taken. Erase beats program, and program beats protect.
- R11: After an operation completes, reads again return true stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_req | input | 1 | Program strobe from the command decoder |
| erase_req | input | 1 | Whole-array erase strobe |
| lock_req | input | 1 | Boot-region protection strobe |
| op_addr | input | ADDR_W | Program target address |
| op_data | input | 8 | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, or status while busy |
| busy | output | 1 | High while an operation is running |

## Verification
`busy` rises on the first edge after an accepted strobe. It falls on the edge that commits the array update, PROG_CYC or ERASE_CYC edges later. Read results appear one edge after the strobe. The data or status returned is the one that held before that edge.

The bench steps a behavioural model once per clock using the same inputs. It compares `busy` every cycle and `rd_data` in the cycle after each read. Outputs are sampled on the falling edge, so every registered result is counted in the correct cycle.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } fe_op_e;
endpackage

// File: rtl/fe_seq.sv
module fe_seq
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BOOT_W    = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              lock_req,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    output logic              busy_o,
    output logic              start_o,
    output logic              commit_prog_o,
    output logic              commit_erase_o,
    output logic              op_prog_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [7:0]        tgt_data_o,
    output logic              locked_o
);
    localparam int CNT_W = $clog2(ERASE_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);

    typedef struct packed {
        logic              busy;
        fe_op_e            op;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              locked;
    } seq_t;

    seq_t s_d, s_q;
    logic fin;
    logic in_boot;

    always_comb begin
        s_d     = s_q;
        start_o = 1'b0;
        fin     = s_q.busy && (s_q.cnt == '0);
        in_boot = ~|op_addr[ADDR_W-1:BOOT_W];
        if (s_q.busy) begin
            if (fin) begin
                s_d.busy = 1'b0;
                s_d.op   = OP_NONE;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (erase_req) begin
            s_d.busy = 1'b1;
            s_d.op   = OP_ERASE;
            s_d.cnt  = ERASE_LD;
            start_o  = 1'b1;
        end else if (prog_req) begin
            if (!(s_q.locked && in_boot)) begin
                s_d.busy = 1'b1;
                s_d.op   = OP_PROG;
                s_d.cnt  = PROG_LD;
                s_d.addr = op_addr;
                s_d.data = op_data;
                start_o  = 1'b1;
            end
        end else if (lock_req) begin
            s_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, op: OP_NONE, cnt: '0, addr: '0, data: '0, locked: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o         = s_q.busy;
    assign commit_prog_o  = fin && (s_q.op == OP_PROG);
    assign commit_erase_o = fin && (s_q.op == OP_ERASE);
    assign op_prog_o      = (s_q.op == OP_PROG);
    assign tgt_addr_o     = s_q.addr;
    assign tgt_data_o     = s_q.data;
    assign locked_o       = s_q.locked;

    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> s_q.busy);
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.locked |=> s_q.locked);
    a_r7_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !fin) |=> ($stable(s_q.addr) && $stable(s_q.data) && $stable(s_q.op)));
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= ERASE_LD);
endmodule

// File: rtl/fe_array.sv
module fe_array #(
    parameter int ADDR_W = 10,
    parameter int BOOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_prog,
    input  logic              commit_erase,
    input  logic              locked,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_word
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BOOT_DEPTH = 1 << BOOT_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (commit_prog) begin
            mem_d[tgt_addr] = mem_q[tgt_addr] & tgt_data;
        end
        if (commit_erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!(locked && i < BOOT_DEPTH)) begin
                    mem_d[i] = 8'hFF;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: 8'hFF};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_word = mem_q[rd_addr];

    a_r3_and_merge: assert property (@(posedge clk) disable iff (!rst_n)
        commit_prog |=> mem_q[$past(tgt_addr)] == ($past(mem_q[tgt_addr]) & $past(tgt_data)));
    a_r4_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        commit_erase |=> mem_q[DEPTH-1] == 8'hFF);
    a_r9_boot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_erase && locked) |=> mem_q[0] == $past(mem_q[0]));
endmodule

// File: rtl/fe_status.sv
module fe_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       busy,
    input  logic       start,
    input  logic       op_prog,
    input  logic       poll_src,
    input  logic [7:0] rd_word,
    output logic [7:0] rd_data
);
    typedef struct packed {
        logic       tog;
        logic [7:0] rd;
    } stat_t;

    stat_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.tog = 1'b0;
        end
        if (rd_en) begin
            if (busy) begin
                t_d.rd  = {(op_prog ? ~poll_src : 1'b0), t_q.tog, 6'b0};
                t_d.tog = ~t_q.tog;
            end else begin
                t_d.rd = rd_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{tog: 1'b0, rd: 8'hFF};
        end else begin
            t_q <= t_d;
        end
    end

    assign rd_data = t_q.rd;

    a_r5_status_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> rd_data[5:0] == 6'b0);
    a_r6_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> t_q.tog != $past(t_q.tog));
    a_r6_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !t_q.tog);
endmodule

// File: rtl/flash_eng.sv
module flash_eng
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BOOT_W    = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              lock_req,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic              start, commit_prog, commit_erase, op_prog, locked;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic [7:0]        rd_word;

    fe_seq #(
        .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .prog_req(prog_req), .erase_req(erase_req), .lock_req(lock_req),
        .op_addr(op_addr), .op_data(op_data),
        .busy_o(busy), .start_o(start),
        .commit_prog_o(commit_prog), .commit_erase_o(commit_erase),
        .op_prog_o(op_prog), .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data),
        .locked_o(locked)
    );

    fe_array #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) array_i (
        .clk(clk), .rst_n(rst_n),
        .commit_prog(commit_prog), .commit_erase(commit_erase), .locked(locked),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .rd_addr(rd_addr), .rd_word(rd_word)
    );

    fe_status status_i (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .busy(busy), .start(start), .op_prog(op_prog),
        .poll_src(tgt_data[7]), .rd_word(rd_word), .rd_data(rd_data)
    );

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: tb/flash_eng_tb_top.sv
module flash_eng_tb_top;
    localparam int ADDR_W     = 10;
    localparam int BOOT_W     = 6;
    localparam int PROG_CYC   = 8;
    localparam int ERASE_CYC  = 40;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BOOT_DEPTH = 1 << BOOT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prog_req = 1'b0, erase_req = 1'b0, lock_req = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] op_addr = '0, rd_addr = '0;
    logic [7:0]        op_data = '0;
    logic [7:0]        rd_data;
    logic              busy;

    always #5 clk = ~clk;

    flash_eng #(
        .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
        .lock_req(lock_req), .op_addr(op_addr), .op_data(op_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    int n_run = 0;
    int n_fail = 0;
    string cur = "R1";

    logic [7:0] m_mem [DEPTH];
    logic       m_busy, m_lock, m_tog, m_rd_v;
    int         m_rem, m_op;
    int         m_addr;
    logic [7:0] m_data, m_rd;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_init();
        foreach (m_mem[i]) m_mem[i] = 8'hFF;
        m_busy = 1'b0; m_lock = 1'b0; m_tog = 1'b0; m_rd_v = 1'b0;
        m_rem = 0; m_op = 0; m_addr = 0; m_data = '0; m_rd = 8'hFF;
    endtask

    task automatic model_step();
        m_rd_v = rd_en;
        if (rd_en) begin
            if (m_busy) begin
                m_rd  = {(m_op == 1) ? ~m_data[7] : 1'b0, m_tog, 6'b0};
                m_tog = ~m_tog;
            end else begin
                m_rd = m_mem[rd_addr];
            end
        end
        if (m_busy) begin
            if (m_rem == 1) begin
                if (m_op == 1) m_mem[m_addr] = m_mem[m_addr] & m_data;
                else for (int i = 0; i < DEPTH; i++)
                    if (!(m_lock && i < BOOT_DEPTH)) m_mem[i] = 8'hFF;
                m_busy = 1'b0;
                m_op   = 0;
            end else begin
                m_rem--;
            end
        end else if (erase_req) begin
            m_busy = 1'b1; m_op = 2; m_rem = ERASE_CYC; m_tog = 1'b0;
        end else if (prog_req) begin
            if (!(m_lock && int'(op_addr) < BOOT_DEPTH)) begin
                m_busy = 1'b1; m_op = 1; m_rem = PROG_CYC; m_tog = 1'b0;
                m_addr = int'(op_addr); m_data = op_data;
            end
        end else if (lock_req) begin
            m_lock = 1'b1;
        end
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        check({cur, " busy"}, int'(busy), int'(m_busy));
        if (m_rd_v) check({cur, " rd_data"}, int'(rd_data), int'(m_rd));
        prog_req = 1'b0; erase_req = 1'b0; lock_req = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_init();
    endtask

    task automatic rd(input int a);
        rd_en = 1'b1; rd_addr = ADDR_W'(a);
        cyc();
    endtask

    task automatic prog(input int a, input logic [7:0] d);
        prog_req = 1'b1; op_addr = ADDR_W'(a); op_data = d;
        cyc();
    endtask

    task automatic settle();
        while (m_busy) cyc();
        cyc();
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_init();
        do_reset();

        cur = "R1";
        check("R1 busy after reset", int'(busy), 0);
        rd(0); rd(100); rd(DEPTH - 1);

        cur = "R3";
        prog(256, 8'hA5);
        settle();
        cur = "R2"; rd(256);
        check("R2 programmed byte", int'(rd_data), 8'hA5);
        cur = "R3";
        prog(256, 8'h0F);
        settle();
        rd(256);
        check("R3 and merge", int'(rd_data), 8'h05);

        cur = "R5";
        prog(512, 8'h80);
        rd(512);
        check("R5 poll bit7 inverted", int'(rd_data[7]), 0);
        cur = "R6";
        check("R6 first toggle zero", int'(rd_data[6]), 0);
        rd(512);
        check("R6 toggle flips", int'(rd_data[6]), 1);
        rd(3); rd(512);
        cur = "R7";
        prog(600, 8'h00);
        erase_req = 1'b1; cyc();
        lock_req = 1'b1; cyc();
        settle();
        cur = "R11"; rd(512);
        check("R11 true data", int'(rd_data), 8'h80);
        cur = "R7"; rd(600);
        check("R7 busy request ignored", int'(rd_data), 8'hFF);

        cur = "R5";
        prog(700, 8'h3C);
        settle();
        cur = "R4";
        erase_req = 1'b1; cyc();
        cur = "R5"; rd(700);
        check("R5 erase status", int'(rd_data), 8'h00);
        cur = "R6"; rd(700); rd(700);
        cur = "R4";
        settle();
        rd(256); rd(700);
        check("R4 erased", int'(rd_data), 8'hFF);

        cur = "R9";
        prog(3, 8'h3C);
        settle();
        cur = "R8";
        lock_req = 1'b1; cyc();
        prog(5, 8'h00);
        check("R8 boot program dropped busy", int'(busy), 0);
        rd(5);
        check("R8 boot byte kept", int'(rd_data), 8'hFF);
        prog(300, 8'h11);
        settle();
        rd(300);
        cur = "R9";
        erase_req = 1'b1; cyc();
        settle();
        rd(3);
        check("R9 boot survives erase", int'(rd_data), 8'h3C);
        rd(300);

        cur = "R10";
        prog_req = 1'b1; erase_req = 1'b1; op_addr = ADDR_W'(400); op_data = 8'h00;
        cyc();
        repeat (PROG_CYC + 2) cyc();
        check("R10 erase wins still busy", int'(busy), 1);
        settle();
        rd(400);

        do_reset();
        cur = "R1"; rd(3);
        cur = "R10";
        prog_req = 1'b1; lock_req = 1'b1; op_addr = ADDR_W'(2); op_data = 8'h00;
        cyc();
        settle();
        prog(1, 8'h00);
        check("R10 lock lost to program", int'(busy), 1);
        settle();
        rd(1); rd(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule